// File: doc/BRIEF.md
# IO-Space Prefix and Bus-Request Controller

This block keeps the short-lived state bits of a microcoded sequencer. A one-instruction prefix flag sends the next instruction's ordinary loads and stores to a separate IO address space instead of normal memory. The flag works like a seventeenth address bit. Every access that lands in the IO space holds the micro-step counter for exactly one cycle. Peripherals get that cycle to answer. The microcode never sees the stall.

The block also holds an interrupt mask with separate set and clear strobes. From the mask and the prefix flag it forms the qualifier that lets a pending interrupt through. It also holds two toggle bits: an interrupt-acknowledge line and a framebuffer select. The sequencer drives decoded control strobes and the access type of the current control word into the block. It takes back the memory/IO routing, the stall and the interrupt qualifier.

During a stall the sequencer presents the same control word a second time. For that reason the block ignores toggle strobes while the stall is high, so a repeated word cannot flip a toggle twice.

Top module: `ioprefix_ctrl`

## Requirements
- R1: After reset the prefix flag, stall, acknowledge and framebuffer select are 0 and the interrupt mask is 1.
- R2: A set-prefix strobe sets the prefix flag at the next edge. An end-of-instruction strobe clears it at the next edge, except when set-prefix is also high in that cycle, in which case the flag stays 1.
- R3: Access type codes are 00 none, 01 regular load, 10 regular store and 11 immediate load. With the prefix flag set and no end-of-instruction strobe, a regular load or store gives io_sel_o=1 and mem_en_o=0. Without the prefix flag it gives io_sel_o=0 and mem_en_o=1. Code 00 gives both 0.
- R4: An instruction fetch (end-of-instruction strobe high) or an immediate load (code 11) always gives mem_en_o=1 and io_sel_o=0, whatever the prefix flag holds, and never raises the stall.
- R5: An IO access while stall_o is low raises stall_o for exactly one cycle. The stall drops after that cycle even if the same IO access is presented again.
- R6: inh_set_i sets the interrupt mask and inh_clr_i clears it, both at the next edge. When both are high, set wins.
- R7: irq_ok_o is high exactly when irq_pend_i is high, the mask is 0 and the prefix flag is 0.
- R8: ack_o flips on each ack_tgl_i strobe and fb_sel_o flips on each fb_tgl_i strobe, independently of each other.
- R9: While stall_o is high, the toggle strobes have no effect on ack_o or fb_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_prefix_i | input | 1 | Strobe that arms the IO-space prefix |
| end_instr_i | input | 1 | End of instruction / fetch of the next opcode |
| acc_kind_i | input | 2 | Memory access type of the current control word |
| inh_set_i | input | 1 | Set the interrupt mask |
| inh_clr_i | input | 1 | Clear the interrupt mask |
| irq_pend_i | input | 1 | An interrupt is pending |
| ack_tgl_i | input | 1 | Toggle the acknowledge output |
| fb_tgl_i | input | 1 | Toggle the framebuffer select |
| io_sel_o | output | 1 | Current access goes to the IO space |
| mem_en_o | output | 1 | Current access goes to normal memory |
| stall_o | output | 1 | Hold the micro-step counter this cycle |
| prefix_o | output | 1 | Prefix flag state |
| inhibit_o | output | 1 | Interrupt mask state |
| irq_ok_o | output | 1 | Pending interrupt may be taken |
| ack_o | output | 1 | Interrupt acknowledge line |
| fb_sel_o | output | 1 | Framebuffer select |

## Verification
Two pairs of functions can coincide.

The first pair is prefix arming and end-of-instruction. The bench drives set-prefix and end-of-instruction in the same cycle and expects the flag to survive into the next instruction, where an immediate load must still go to memory and a store must go to the IO space.

The second pair is a toggle strobe and the bus-request stall. The bench repeats a control word that carries an acknowledge toggle across the stall cycle, as the sequencer would. It then judges that the acknowledge line flipped once, not twice, and that the stall fell even though the IO access was still presented.

// File: rtl/iopc_pkg.sv
package iopc_pkg;

  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    ACC_NONE  = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_IMM   = 2'b11
  } acc_kind_e;

  // regular data access that may be redirected
  function automatic logic is_regular(input acc_kind_e k);
    return (k == ACC_LOAD) || (k == ACC_STORE);
  endfunction

  // IO routing: prefix armed, regular access, not an opcode fetch
  function automatic logic io_route(input logic pre, input acc_kind_e k, input logic fetch);
    return pre && is_regular(k) && !fetch;
  endfunction

  // normal memory routing
  function automatic logic mem_route(input acc_kind_e k, input logic fetch, input logic io);
    return (fetch || (k != ACC_NONE)) && !io;
  endfunction

  // next value of the prefix flag
  function automatic logic prefix_next(input logic cur, input logic arm, input logic fin);
    if (arm) return 1'b1;
    if (fin) return 1'b0;
    return cur;
  endfunction

  // interrupt qualifier
  function automatic logic irq_pass(input logic pend, input logic mask, input logic pre);
    return pend && !mask && !pre;
  endfunction

endpackage

// File: rtl/iopc_prefix_unit.sv
module iopc_prefix_unit
  import iopc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_prefix,
  input  logic      end_instr,
  input  acc_kind_e kind,
  output logic      prefix_q,
  output logic      busreq_q,
  output logic      io_sel,
  output logic      mem_en
);

  logic io_evt;     // an IO-space access is on the bus this cycle
  logic stall_req;  // access wants a fresh stall cycle
  logic pre_nxt;
  logic bus_nxt;

  assign io_evt    = io_route(prefix_q, kind, end_instr);
  assign stall_req = io_evt && !busreq_q;
  assign pre_nxt   = prefix_next(prefix_q, set_prefix, end_instr);
  assign bus_nxt   = stall_req;

  assign io_sel = io_evt;
  assign mem_en = mem_route(kind, end_instr, io_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prefix_q <= 1'b0;
      busreq_q <= 1'b0;
    end else begin
      prefix_q <= pre_nxt;
      busreq_q <= bus_nxt;
    end
  end

endmodule

// File: rtl/iopc_irq_gate.sv
module iopc_irq_gate
  import iopc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inh_set,
  input  logic inh_clr,
  input  logic irq_pend,
  input  logic prefix,
  output logic inh_q,
  output logic irq_ok
);

  logic inh_nxt;

  always_comb begin
    inh_nxt = inh_q;
    if (inh_clr) inh_nxt = 1'b0;
    if (inh_set) inh_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inh_q <= 1'b1;
    else        inh_q <= inh_nxt;
  end

  assign irq_ok = irq_pass(irq_pend, inh_q, prefix);

endmodule

// File: rtl/iopc_toggle_bank.sv
module iopc_toggle_bank #(
  parameter int TGL_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [TGL_N-1:0] tgl,
  output logic [TGL_N-1:0] q
);

  logic [TGL_N-1:0] flip;

  for (genvar i = 0; i < TGL_N; i++) begin : g_bit
    assign flip[i] = tgl[i] && !hold;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[i] <= 1'b0;
      else if (flip[i]) q[i] <= !q[i];
    end
  end

endmodule

// File: rtl/ioprefix_ctrl.sv
module ioprefix_ctrl
  import iopc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_prefix_i,
  input  logic              end_instr_i,
  input  logic [KIND_W-1:0] acc_kind_i,
  input  logic              inh_set_i,
  input  logic              inh_clr_i,
  input  logic              irq_pend_i,
  input  logic              ack_tgl_i,
  input  logic              fb_tgl_i,
  output logic              io_sel_o,
  output logic              mem_en_o,
  output logic              stall_o,
  output logic              prefix_o,
  output logic              inhibit_o,
  output logic              irq_ok_o,
  output logic              ack_o,
  output logic              fb_sel_o
);

  localparam int TGL_ACK = 0;
  localparam int TGL_FB  = 1;
  localparam int TGL_N   = TGL_FB + 1;

  acc_kind_e        kind;
  logic             prefix_q;
  logic             busreq_q;
  logic [TGL_N-1:0] tgl_vec;
  logic [TGL_N-1:0] tgl_q;

  assign kind = acc_kind_e'(acc_kind_i);

  iopc_prefix_unit u_prefix (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_prefix (set_prefix_i),
    .end_instr  (end_instr_i),
    .kind       (kind),
    .prefix_q   (prefix_q),
    .busreq_q   (busreq_q),
    .io_sel     (io_sel_o),
    .mem_en     (mem_en_o)
  );

  iopc_irq_gate u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .inh_set  (inh_set_i),
    .inh_clr  (inh_clr_i),
    .irq_pend (irq_pend_i),
    .prefix   (prefix_q),
    .inh_q    (inhibit_o),
    .irq_ok   (irq_ok_o)
  );

  assign tgl_vec[TGL_ACK] = ack_tgl_i;
  assign tgl_vec[TGL_FB]  = fb_tgl_i;

  iopc_toggle_bank #(.TGL_N(TGL_N)) u_tgl (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (busreq_q),
    .tgl   (tgl_vec),
    .q     (tgl_q)
  );

  assign stall_o  = busreq_q;
  assign prefix_o = prefix_q;
  assign ack_o    = tgl_q[TGL_ACK];
  assign fb_sel_o = tgl_q[TGL_FB];

endmodule

// File: rtl/ioprefix_ctrl_chk.sv
module ioprefix_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_prefix_i,
  input logic       end_instr_i,
  input logic [1:0] acc_kind_i,
  input logic       inh_set_i,
  input logic       inh_clr_i,
  input logic       irq_pend_i,
  input logic       ack_tgl_i,
  input logic       fb_tgl_i,
  input logic       io_sel_o,
  input logic       mem_en_o,
  input logic       stall_o,
  input logic       prefix_o,
  input logic       inhibit_o,
  input logic       irq_ok_o,
  input logic       ack_o,
  input logic       fb_sel_o
);

  AST_PREFIX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    set_prefix_i |=> prefix_o); // R2

  AST_PREFIX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (end_instr_i && !set_prefix_i) |=> !prefix_o); // R2

  AST_FETCH_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (end_instr_i || acc_kind_i == 2'b11) |-> (mem_en_o && !io_sel_o)); // R4

  AST_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel_o && !stall_o) |=> stall_o); // R5

  AST_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !stall_o); // R5

  AST_INH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    inh_set_i |=> inhibit_o); // R6

  AST_INH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_clr_i && !inh_set_i) |=> !inhibit_o); // R6

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (prefix_o || inhibit_o) |-> !irq_ok_o); // R7

  AST_ACK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tgl_i && !stall_o) |=> (ack_o != $past(ack_o))); // R8

  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> ($stable(ack_o) && $stable(fb_sel_o))); // R9

endmodule

bind ioprefix_ctrl ioprefix_ctrl_chk u_chk (.*);

// File: tb/ioprefix_ctrl_test.sv
`timescale 1ns/100ps
module ioprefix_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_prefix_i = 0, end_instr_i = 0;
  logic [1:0] acc_kind_i = 2'b00;
  logic       inh_set_i = 0, inh_clr_i = 0, irq_pend_i = 0;
  logic       ack_tgl_i = 0, fb_tgl_i = 0;
  logic       io_sel_o, mem_en_o, stall_o, prefix_o, inhibit_o, irq_ok_o, ack_o, fb_sel_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [4:0] st;   // {prefix, stall, mask, ack, fb}
    string      tag;
  } exp_t;
  exp_t sb[$];

  // bench reference state
  logic m_pre = 0, m_bus = 0, m_inh = 1, m_ack = 0, m_fb = 0;

  always #2 clk = ~clk;

  ioprefix_ctrl uut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: one control word per call
  task automatic drive(input logic sp, input logic ei, input logic [1:0] k,
                       input logic is_, input logic ic, input logic ip,
                       input logic at, input logic ft, input string tag);
    logic regular, io, me, ok;
    exp_t e;
    @(negedge clk);
    set_prefix_i = sp; end_instr_i = ei; acc_kind_i = k;
    inh_set_i = is_; inh_clr_i = ic; irq_pend_i = ip;
    ack_tgl_i = at; fb_tgl_i = ft;
    #0.5;
    regular = (k == 2'b01) | (k == 2'b10);
    io = m_pre & regular & ~ei;
    me = ~io & (ei | (k != 2'b00));
    ok = ip & ~m_inh & ~m_pre;
    check(tag, {4'b0, io_sel_o, mem_en_o, stall_o, irq_ok_o}, {4'b0, io, me, m_bus, ok});
    if (!m_bus) begin
      m_ack = m_ack ^ at;
      m_fb  = m_fb ^ ft;
    end
    m_bus = io & ~m_bus;
    m_pre = sp ? 1'b1 : (ei ? 1'b0 : m_pre);
    m_inh = is_ ? 1'b1 : (ic ? 1'b0 : m_inh);
    e.st  = {m_pre, m_bus, m_inh, m_ack, m_fb};
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares state after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, {3'b0, prefix_o, stall_o, inhibit_o, ack_o, fb_sel_o}, {3'b0, e.st});
      end
    end
  end

  initial begin
    #(4 * 50000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {3'b0, prefix_o, stall_o, inhibit_o, ack_o, fb_sel_o}, 8'b0000_0100);
    rst_n = 1'b1;
    // sp ei kind is ic ip at ft
    drive(0, 0, 2'b00, 0, 0, 1, 0, 0, "R7");   // masked, no access
    drive(0, 0, 2'b00, 0, 1, 1, 0, 0, "R6");   // clear mask
    drive(0, 0, 2'b00, 0, 0, 1, 0, 0, "R7");   // interrupt passes
    drive(0, 0, 2'b01, 0, 0, 0, 0, 0, "R3");   // plain load -> memory
    drive(1, 0, 2'b10, 0, 0, 0, 0, 0, "R3");   // store, arm prefix
    drive(0, 0, 2'b00, 0, 0, 1, 0, 0, "R7");   // prefix masks interrupt
    drive(0, 0, 2'b01, 0, 0, 0, 1, 0, "R5");   // IO load + ack toggle
    drive(0, 0, 2'b01, 0, 0, 0, 1, 0, "R9");   // repeated word in stall
    drive(0, 1, 2'b00, 0, 0, 0, 0, 0, "R4");   // fetch clears prefix
    drive(0, 0, 2'b10, 0, 0, 1, 0, 0, "R2");   // prefix gone
    drive(1, 1, 2'b00, 0, 0, 0, 0, 0, "R2");   // arm with fetch: survives
    drive(0, 0, 2'b11, 0, 0, 0, 0, 0, "R4");   // immediate load ignores prefix
    drive(0, 0, 2'b10, 0, 0, 0, 0, 1, "R5");   // IO store + fb toggle
    drive(0, 0, 2'b10, 0, 0, 0, 0, 1, "R9");   // repeat while stalled
    drive(0, 0, 2'b10, 0, 0, 0, 0, 0, "R5");   // fresh stall again
    drive(0, 0, 2'b10, 0, 0, 0, 0, 0, "R5");   // and drops
    drive(0, 1, 2'b00, 1, 1, 1, 0, 0, "R6");   // set wins over clear
    drive(0, 0, 2'b00, 0, 0, 0, 1, 1, "R8");   // both toggles
    drive(0, 0, 2'b00, 0, 0, 0, 0, 1, "R8");   // fb only
    drive(0, 0, 2'b00, 0, 1, 0, 0, 0, "R6");   // clear mask
    drive(0, 0, 2'b00, 0, 0, 1, 0, 0, "R7");
    drive(0, 0, 2'b00, 0, 0, 0, 0, 0, "R3");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule